// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Register with Per-Bit Access Filtering

This block gathers readiness and failure events from six clock sources into one 32-bit status word. Four oscillators, one PLL and a monitor on the external high-speed clock each own one sticky flag. The oscillators are a low-speed internal one, a low-speed external one, a high-speed internal one and a high-speed external one. Hardware sets a flag when its source reports stable (or locked) while the matching enable is on. The clock-failure flag is raised whenever the monitor reports a fault. Software reads the flags at one bus address and acknowledges them by writing ones to a second address, the clear register. The flag word itself cannot be written.

Every bit is filtered per access. Each source has its own secure attribute, and the two high-speed external flags share one. Two privilege-control bits, one for secure-attributed bits and one for non-secure bits, decide whether unprivileged access is refused. A refused access reads zero and its clear has no effect, and no fault is signalled. The interrupt line is the OR of all six flags. The bus has no data stream: it is a single-cycle register port with no back-pressure, so there is no valid/ready handshake.

Top module: `clkflag_irq_reg`

## Requirements
- R1: After reset all six flags are 0, a read of the flag word returns 0 and `irq` is 0. Flag bit positions are: 0 low-speed internal, 1 low-speed external, 2 high-speed internal, 3 high-speed external, 4 PLL, 5 clock failure. The `ready_evt`/`ready_ie`/`sec_attr` index for each source equals its flag bit (0..4).
- R2: A ready flag (bits 0, 1, 3, 4) becomes 1 on the clock edge where its `ready_evt` bit is 1 together with its `ready_ie` bit. With the enable at 0 the event leaves the flag at 0.
- R3: The high-speed internal flag (bit 2) is set only when `hsi_sw_on` is 1 in addition to its event and enable. With `hsi_sw_on` at 0 the flag stays 0.
- R4: `css_fail` sets flag bit 5 on the next edge, with no enable needed.
- R5: Writing 1 to a bit of the clear register (`bus_addr`=1) clears that flag at the write edge, and writing 0 leaves it. Writes to the flag word (`bus_addr`=0) change nothing.
- R6: If a set event and a clear write hit the same flag in the same cycle, the flag ends at 1.
- R7: If a bit's secure attribute is 1, a non-secure access reads that bit as 0 and its clear write is ignored. Bits 3 and 5 both follow `sec_attr[3]`.
- R8: For a bit whose secure attribute is 1, `priv_sec_ctl`=1 makes unprivileged accesses read 0 and have their clears ignored. For a bit whose attribute is 0, `priv_ns_ctl` does the same.
- R9: `irq` is 1 exactly while at least one flag is 1.
- R10: Bits 31..6 of the flag word always read 0, and a read of the clear register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_evt | input | 5 | Per-source stable/locked event, one per cycle |
| ready_ie | input | 5 | Per-source ready interrupt enable |
| hsi_sw_on | input | 1 | High-speed internal oscillator was enabled by software |
| css_fail | input | 1 | External clock monitor failure event |
| sec_attr | input | 5 | Per-source secure attribute (index 3 also covers bit 5) |
| priv_sec_ctl | input | 1 | Privilege protection for secure-attributed bits |
| priv_ns_ctl | input | 1 | Privilege protection for non-secure bits |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = flag word, 1 = clear register |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, valid combinationally during a read |
| irq | output | 1 | OR of all flags |

## Verification
Each event is driven alone, once for every combination of its enable and of `hsi_sw_on`. This separates the gated ready flags from the software-qualified internal one and from the always-armed failure flag. The access filter is swept across all 32 secure-attribute patterns, all four privilege-control settings and all four access kinds. At each point a read of a fully set word shows which bits are visible, and a clear-all followed by a trusted read shows which bits were really cleared. That tells a read-path error apart from a clear-path error. Directed cases cover clear-against-set collisions, writes to the read-only word, zero writes and the unused upper bits.

// File: rtl/clkflag_pkg.sv
package clkflag_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_READY = 5;

  localparam int FLG_LSI  = 0;
  localparam int FLG_LSE  = 1;
  localparam int FLG_HSI  = 2;
  localparam int FLG_HSE  = 3;
  localparam int FLG_PLL  = 4;
  localparam int FLG_FAIL = 5;

  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_CLEAR = 1'b1;

  // attribute domain that governs a flag bit
  function automatic int attr_domain(input int bit_idx);
    return (bit_idx == FLG_FAIL) ? FLG_HSE : bit_idx;
  endfunction
endpackage

// File: rtl/clkflag_access_filter.sv
module clkflag_access_filter
  import clkflag_pkg::*;
(
  input  logic [NUM_READY-1:0] sec_attr,
  input  logic                 priv_sec_ctl,
  input  logic                 priv_ns_ctl,
  input  logic                 bus_secure,
  input  logic                 bus_priv,
  output logic [NUM_FLAGS-1:0] allow
);
  for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_bit
    localparam int DOM = attr_domain(b);
    logic is_sec;
    logic guarded;
    logic sec_ok;
    logic priv_ok;
    assign is_sec  = sec_attr[DOM];
    assign guarded = is_sec ? priv_sec_ctl : priv_ns_ctl;
    assign sec_ok  = !is_sec || bus_secure;
    assign priv_ok = !guarded || bus_priv;
    assign allow[b] = sec_ok && priv_ok;
  end
endmodule

// File: rtl/clkflag_cell.sv
module clkflag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;   // set has priority over clear
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/clkflag_irq_reg.sv
module clkflag_irq_reg
  import clkflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_READY-1:0] ready_evt,
  input  logic [NUM_READY-1:0] ready_ie,
  input  logic                 hsi_sw_on,
  input  logic                 css_fail,
  input  logic [NUM_READY-1:0] sec_attr,
  input  logic                 priv_sec_ctl,
  input  logic                 priv_ns_ctl,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic                 bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_secure,
  input  logic                 bus_priv,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] allow;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 clr_hit;
  logic                 rd_hit;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_FLAGS];

  clkflag_access_filter u_filter (
    .sec_attr     (sec_attr),
    .priv_sec_ctl (priv_sec_ctl),
    .priv_ns_ctl  (priv_ns_ctl),
    .bus_secure   (bus_secure),
    .bus_priv     (bus_priv),
    .allow        (allow)
  );

  // set conditions per source
  for (genvar s = 0; s < NUM_READY; s++) begin : g_set
    if (s == FLG_HSI) begin : g_hsi
      assign set_vec[s] = ready_evt[s] && ready_ie[s] && hsi_sw_on;
    end else begin : g_rdy
      assign set_vec[s] = ready_evt[s] && ready_ie[s];
    end
  end
  assign set_vec[FLG_FAIL] = css_fail;

  assign clr_hit = bus_en && bus_we && (bus_addr == ADDR_CLEAR);
  assign rd_hit  = bus_en && !bus_we && (bus_addr == ADDR_FLAGS);
  assign clr_vec = clr_hit ? (bus_wdata[NUM_FLAGS-1:0] & allow) : '0;

  for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
    clkflag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[b]),
      .clr_i (clr_vec[b]),
      .q     (flag_q[b])
    );
  end

  assign bus_rdata = rd_hit ? {{PAD_W{1'b0}}, flag_q & allow} : '0;
  assign irq       = |flag_q;
endmodule

// File: rtl/clkflag_irq_reg_chk.sv
module clkflag_irq_reg_chk
  import clkflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_READY-1:0] ready_evt,
  input logic [NUM_READY-1:0] ready_ie,
  input logic                 hsi_sw_on,
  input logic                 css_fail,
  input logic [NUM_READY-1:0] sec_attr,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic                 bus_addr,
  input logic                 bus_secure,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 irq,
  input logic [NUM_FLAGS-1:0] flag_q
);
  assert_ready_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt[FLG_LSE] && ready_ie[FLG_LSE]) |=> flag_q[FLG_LSE]);

  assert_hsi_needs_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt[FLG_HSI] && !hsi_sw_on && !flag_q[FLG_HSI]) |=> !flag_q[FLG_HSI]);

  assert_fail_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    css_fail |=> (flag_q[FLG_FAIL] && irq));

  assert_flagword_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_FLAGS && ready_evt == '0 && !css_fail)
      |=> $stable(flag_q));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (css_fail && bus_en && bus_we && bus_addr == ADDR_CLEAR) |=> flag_q[FLG_FAIL]);

  assert_secure_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !bus_secure && sec_attr[FLG_HSE])
      |-> (bus_rdata[FLG_HSE] == 1'b0 && bus_rdata[FLG_FAIL] == 1'b0));

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_en && bus_we && bus_addr == ADDR_CLEAR)) |=> irq);

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_FLAGS] == '0);
endmodule

bind clkflag_irq_reg clkflag_irq_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_evt  (ready_evt),
  .ready_ie   (ready_ie),
  .hsi_sw_on  (hsi_sw_on),
  .css_fail   (css_fail),
  .sec_attr   (sec_attr),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_secure (bus_secure),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .flag_q     (flag_q)
);

// File: tb/clkflag_irq_reg_bench.sv
`timescale 1ns/1ps
module clkflag_irq_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ready_evt = '0;
  logic [4:0]  ready_ie = '0;
  logic        hsi_sw_on = 1'b0;
  logic        css_fail = 1'b0;
  logic [4:0]  sec_attr = '0;
  logic        priv_sec_ctl = 1'b0;
  logic        priv_ns_ctl = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_secure = 1'b0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  clkflag_irq_reg u_clkflag_irq_reg (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic addr, input logic s, input logic p, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr; bus_secure = s; bus_priv = p;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic addr, input logic [31:0] data, input logic s, input logic p);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    bus_secure = s; bus_priv = p;
    tick();
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic set_all();
    ready_evt = 5'h1F; ready_ie = 5'h1F; hsi_sw_on = 1'b1; css_fail = 1'b1;
    tick();
    ready_evt = '0; ready_ie = '0; hsi_sw_on = 1'b0; css_fail = 1'b0;
  endtask

  task automatic wipe();
    sec_attr = '0; priv_sec_ctl = 1'b0; priv_ns_ctl = 1'b0;
    wr(1'b1, 32'h3F, 1'b1, 1'b1);
  endtask

  // expected visibility mask from R7/R8
  function automatic logic [31:0] vis(input logic [4:0] sa, input logic ps, input logic pn,
                                      input logic s, input logic p);
    logic [31:0] m = '0;
    for (int b = 0; b < 6; b++) begin
      int d = (b == 5) ? 3 : b;
      logic sb = sa[d];
      logic g = sb ? ps : pn;
      m[b] = (!sb || s) && (!g || p);
    end
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R1 reset flags", d, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2/R3/R4/R9 single-event sweep
    for (int f = 0; f < 6; f++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int sw = 0; sw < 2; sw++) begin
          logic [31:0] e;
          wipe();
          if (f == 5) css_fail = 1'b1; else ready_evt = 5'(1 << f);
          ready_ie = ie[0] ? 5'h1F : 5'h00;
          hsi_sw_on = sw[0];
          tick();
          ready_evt = '0; ready_ie = '0; hsi_sw_on = 1'b0; css_fail = 1'b0;
          if (f == 5) e = 32'h20;
          else if (ie == 1 && (f != 2 || sw == 1)) e = 32'(1 << f);
          else e = 32'h0;
          rd(1'b0, 1'b1, 1'b1, d);
          chk(f == 5 ? "R4 failure flag" : (f == 2 ? "R3 internal ready gating" : "R2 ready gating"), d, e);
          chk("R9 irq follows flags", {31'b0, irq}, {31'b0, (e != 0)});
        end
      end
    end

    // R2 enable alone does nothing
    wipe();
    ready_ie = 5'h1F; hsi_sw_on = 1'b1; tick(); ready_ie = '0; hsi_sw_on = 1'b0;
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R2 enable without event", d, 32'h0);

    // R5 flag word read-only, zero writes to clear register, partial clear
    set_all();
    wr(1'b0, 32'h0, 1'b1, 1'b1);
    wr(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R5 flag word write ignored", d, 32'h3F);
    wr(1'b1, 32'h0, 1'b1, 1'b1);
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R5 zero clear ignored", d, 32'h3F);
    wr(1'b1, 32'h05, 1'b1, 1'b1);
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R5 partial clear", d, 32'h3A);

    // R6 set beats clear
    ready_evt = 5'h01; ready_ie = 5'h01; css_fail = 1'b1;
    wr(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
    ready_evt = '0; ready_ie = '0; css_fail = 1'b0;
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R6 set wins over clear", d, 32'h21);
    chk("R9 irq with pending flags", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h3F, 1'b1, 1'b1);
    chk("R9 irq after clear all", {31'b0, irq}, 32'h0);

    // R10 clear register reads zero, upper bits zero
    set_all();
    rd(1'b1, 1'b1, 1'b1, d);
    chk("R10 clear register reads 0", d, 32'h0);
    wr(1'b1, 32'hFFFF_FFC0, 1'b1, 1'b1);
    rd(1'b0, 1'b1, 1'b1, d);
    chk("R10 upper bits zero", d, 32'h3F);

    // R7/R8 exhaustive filter sweep
    for (int sa = 0; sa < 32; sa++) begin
      for (int pc = 0; pc < 4; pc++) begin
        for (int ac = 0; ac < 4; ac++) begin
          logic [31:0] m;
          wipe();
          set_all();
          sec_attr = 5'(sa); priv_sec_ctl = pc[1]; priv_ns_ctl = pc[0];
          m = vis(5'(sa), pc[1], pc[0], ac[1], ac[0]);
          rd(1'b0, ac[1], ac[0], d);
          chk("R7 R8 filtered read", d, m);
          wr(1'b1, 32'h3F, ac[1], ac[0]);
          rd(1'b0, 1'b1, 1'b1, d);
          chk("R7 R8 filtered clear", d, 32'h3F & ~m);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule